// File: doc/BRIEF.md
# Serial DAC Frame Writer

This block turns one request into a 24-bit write for a three-wire serial DAC. The request carries a 2-bit operating mode and a 16-bit two's-complement output code, and it is taken through a valid/ready handshake. The block drives a frame strobe (`link_sync`, active low), a serial clock (`link_sclk`) and a serial data line (`link_sdo`). Every interval on these wires is a whole number of system clock cycles, and each interval is set by a parameter. The designer picks the parameters so that the DAC's limits are met at the system clock in use.

A frame is 6 zero pad bits, then the mode, then the code, sent most significant bit first. Internally it goes out as three 8-bit loads of a byte-wide shifter, and the strobe stays low across all three bytes. The shifter may be built to shift out least significant bit first. In that case each byte is mirrored before it is loaded, so the wire order does not change. Between frames the strobe rests low to save power. Before each new frame it is raised for a programmed number of cycles. An abort input can cancel a write that is in flight. `busy` covers each write from acceptance until the settle gap after the last clock edge has passed.

Top module: `dac_frame_writer`

## Requirements
- R1: While reset is asserted and on the first cycle after it: `link_sync` = 0, `link_sclk` = 0, `busy` = 0, `req_ready` = 1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle `busy` = 1 and `req_ready` = 0. `req_valid` held while busy starts no frame.
- R3: Each frame has exactly 24 falling `link_sclk` edges. The bit sampled at the k-th falling edge is bit 24-k of {6'b000000, mode[1:0], code[15:0]}. So the mode sits in frame bits 17:16 and the code in bits 15:0, most significant bit first. This holds whichever bit order the internal byte shifter uses.
- R4: `link_sclk` rests low and is never high while `link_sync` is high. Its first rise comes HALF_CYC cycles after `link_sync` falls. Each high phase and each low phase lasts HALF_CYC cycles.
- R5: `link_sdo` changes only in the cycle where `link_sclk` rises, so it holds still across every falling edge.
- R6: Before each frame, `link_sync` is high for at least SYNC_HI_CYC cycles before it falls. It is exactly SYNC_HI_CYC cycles when no abort occurs.
- R7: While idle (`req_ready` = 1), `link_sync` and `link_sclk` are both low.
- R8: `busy` stays 1 until POST_CYC cycles after the 24th falling edge and is 0 on that cycle. From the 24th falling edge to the next fall of `link_sync` there are at least POST_CYC + SYNC_HI_CYC cycles.
- R9: `abort_req` during the strobe-high lead or the clocking phase gives `link_sync` = 1 and `link_sclk` = 0 in the next cycle. That frame is not completed. The block returns to idle with `req_ready` = 1 after SYNC_HI_CYC strobe-high cycles.
- R10: `abort_req` while idle has no effect: `req_ready` stays 1 and `link_sync` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_mode | input | 2 | Operating-mode field of the frame |
| req_code | input | 16 | Two's-complement output code |
| abort_req | input | 1 | Cancel the write in flight |
| link_sync | output | 1 | Frame strobe to the DAC, active low |
| link_sclk | output | 1 | Serial clock, rests low |
| link_sdo | output | 1 | Serial data, changes on rising clock edges |
| busy | output | 1 | Write or settle gap in progress |

## Verification
The bench builds the block with HALF_CYC = 4, SYNC_HI_CYC = 7, POST_CYC = 20 and the least-significant-first shifter variant. With these values the per-byte mirroring path is exercised, and the strobe-high lead is shorter than the settle gap, so each interval is checked against its own parameter. A 40 ns serial clock period lets many frames run back to back. Aborts can then land in the lead, early in the clocking phase and in the third byte, all within a short run.

// File: rtl/dfw_pkg.sv
package dfw_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int BYTE_W     = 8;
  localparam int NBYTES     = 3;
  localparam int FRAME_BITS = BYTE_W * NBYTES;
  localparam int MODE_W     = 2;
  localparam int CODE_W     = 16;
  localparam int PAD_W      = FRAME_BITS - MODE_W - CODE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TAIL,
    ST_RECOVER
  } dfw_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/dfw_frame_pack.sv
module dfw_frame_pack
  import dfw_pkg::*;
#(
  parameter bit LSB_FIRST = 1'b1
) (
  input  logic [MODE_W-1:0]     mode_i,
  input  logic [CODE_W-1:0]     code_i,
  output logic [FRAME_BITS-1:0] frame_o
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [FRAME_BITS-1:0] word;
  assign word = {{PAD_W{1'b0}}, mode_i, code_i};

  // Byte g is the g-th byte on the wire; it sits at the top of frame_o for g = 0.
  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    localparam int HI = (NBYTES - g) * BYTE_W - 1;
    if (LSB_FIRST) begin : g_mirror
      for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
        assign frame_o[HI - b] = word[HI - (BYTE_W - 1 - b)];
      end
    end else begin : g_plain
      assign frame_o[HI -: BYTE_W] = word[HI -: BYTE_W];
    end
  end
endmodule

// File: rtl/dfw_byte_shifter.sv
module dfw_byte_shifter
  import dfw_pkg::*;
#(
  parameter bit LSB_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  input  logic              step,
  output logic              bit_o
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [BYTE_W-1:0] sr;

  if (LSB_FIRST) begin : g_lsb
    assign bit_o = sr[0];
    always_ff @(posedge clk) begin
      if (rst)       sr <= '0;
      else if (load) sr <= din;
      else if (step) sr <= {1'b0, sr[BYTE_W-1:1]};
    end
  end else begin : g_msb
    assign bit_o = sr[BYTE_W-1];
    always_ff @(posedge clk) begin
      if (rst)       sr <= '0;
      else if (load) sr <= din;
      else if (step) sr <= {sr[BYTE_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/dfw_seq.sv
module dfw_seq
  import dfw_pkg::*;
#(
  parameter int HALF_CYC    = 5,
  parameter int SYNC_HI_CYC = 10,
  parameter int POST_CYC    = 20
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [FRAME_BITS-1:0] frame_i,
  input  logic                  abort_req,
  output logic                  shift_load,
  output logic [BYTE_W-1:0]     shift_byte,
  output logic                  shift_step,
  input  logic                  shift_bit,
  output logic                  link_sync,
  output logic                  link_sclk,
  output logic                  link_sdo,
  output logic                  busy,
  output dfw_state_e            state_o
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int CNT_MAX  = max3(HALF_CYC, SYNC_HI_CYC, POST_CYC);
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam int BIT_W    = $clog2(FRAME_BITS + 1);
  localparam int BIDX_W   = $clog2(NBYTES);
  localparam int LAST_BIT = FRAME_BITS - 1;

  dfw_state_e            state;
  logic [CNT_W-1:0]      cnt;
  logic [BIT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-1:0] frame_q;
  logic                  sync_q, sclk_q, sdo_q;

  logic                  half_done, lead_done, post_done, cancel;
  logic [BIT_W-1:0]      nxt_bit;
  logic                  byte_end;
  logic [BIDX_W-1:0]     byte_idx;
  int                    sel_hi;

  assign half_done = (cnt == CNT_W'(HALF_CYC - 1));
  assign lead_done = (cnt == CNT_W'(SYNC_HI_CYC - 1));
  assign post_done = (cnt == CNT_W'(POST_CYC - 1));
  assign cancel    = abort_req && (state == ST_LEAD || state == ST_SHIFT);

  assign nxt_bit  = bit_cnt + BIT_W'(1);
  assign byte_end = ((nxt_bit % BIT_W'(BYTE_W)) == '0);

  always_comb begin
    if (state == ST_SHIFT) byte_idx = BIDX_W'(nxt_bit / BIT_W'(BYTE_W));
    else                   byte_idx = '0;
    sel_hi     = FRAME_BITS - 1 - int'(byte_idx) * BYTE_W;
    shift_byte = frame_q[sel_hi -: BYTE_W];
  end

  // Advance the shifter on each rising serial clock; reload it at each byte boundary.
  assign shift_step = (state == ST_SHIFT) && !abort_req && half_done && !sclk_q;
  assign shift_load = !abort_req &&
                      (((state == ST_LEAD) && lead_done) ||
                       ((state == ST_SHIFT) && half_done && sclk_q && byte_end &&
                        (bit_cnt != BIT_W'(LAST_BIT))));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bit_cnt <= '0;
      frame_q <= '0;
      sync_q  <= 1'b0;
      sclk_q  <= 1'b0;
      sdo_q   <= 1'b0;
    end else if (cancel) begin
      state  <= ST_RECOVER;
      cnt    <= '0;
      sync_q <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            frame_q <= frame_i;
            sync_q  <= 1'b1;
            cnt     <= '0;
            state   <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (lead_done) begin
            sync_q  <= 1'b0;
            cnt     <= '0;
            bit_cnt <= '0;
            state   <= ST_SHIFT;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_SHIFT: begin
          if (half_done) begin
            cnt    <= '0;
            sclk_q <= ~sclk_q;
            if (!sclk_q) begin
              sdo_q <= shift_bit;
            end else begin
              bit_cnt <= nxt_bit;
              if (bit_cnt == BIT_W'(LAST_BIT)) state <= ST_TAIL;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_TAIL: begin
          if (post_done) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_RECOVER: begin
          if (lead_done) begin
            cnt    <= '0;
            sync_q <= 1'b0;
            state  <= ST_IDLE;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign link_sync = sync_q;
  assign link_sclk = sclk_q;
  assign link_sdo  = sdo_q;
  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign state_o   = state;
endmodule

// File: rtl/dac_frame_writer.sv
module dac_frame_writer
  import dfw_pkg::*;
#(
  parameter int HALF_CYC    = 5,
  parameter int SYNC_HI_CYC = 10,
  parameter int POST_CYC    = 20,
  parameter bit LSB_FIRST   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [MODE_W-1:0] req_mode,
  input  logic [CODE_W-1:0] req_code,
  input  logic              abort_req,
  output logic              link_sync,
  output logic              link_sclk,
  output logic              link_sdo,
  output logic              busy
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [FRAME_BITS-1:0] packed_frame;
  logic                  sh_load, sh_step, sh_bit;
  logic [BYTE_W-1:0]     sh_byte;
  dfw_state_e            seq_state;

  dfw_frame_pack #(.LSB_FIRST(LSB_FIRST)) u_pack (
    .mode_i (req_mode),
    .code_i (req_code),
    .frame_o(packed_frame)
  );

  dfw_byte_shifter #(.LSB_FIRST(LSB_FIRST)) u_shift (
    .clk  (clk),
    .rst  (rst),
    .load (sh_load),
    .din  (sh_byte),
    .step (sh_step),
    .bit_o(sh_bit)
  );

  dfw_seq #(
    .HALF_CYC   (HALF_CYC),
    .SYNC_HI_CYC(SYNC_HI_CYC),
    .POST_CYC   (POST_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .frame_i   (packed_frame),
    .abort_req (abort_req),
    .shift_load(sh_load),
    .shift_byte(sh_byte),
    .shift_step(sh_step),
    .shift_bit (sh_bit),
    .link_sync (link_sync),
    .link_sclk (link_sclk),
    .link_sdo  (link_sdo),
    .busy      (busy),
    .state_o   (seq_state)
  );
endmodule

// File: rtl/dfw_checker.sv
module dfw_checker
  import dfw_pkg::*;
#(
  parameter int SYNC_HI_CYC = 10
) (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic       abort_req,
  input logic       link_sync,
  input logic       link_sclk,
  input logic       link_sdo,
  input logic       busy,
  input dfw_state_e seq_state
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int HW = $clog2(SYNC_HI_CYC + 2);
  logic [HW-1:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst)                                hi_run <= '0;
    else if (!link_sync)                    hi_run <= '0;
    else if (hi_run != HW'(SYNC_HI_CYC))    hi_run <= hi_run + HW'(1);
  end

  a_r2_accept_starts_write: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (busy && link_sync && !req_ready));

  a_r4_sclk_low_while_strobe_high: assert property (@(posedge clk) disable iff (rst)
    link_sync |-> !link_sclk);

  a_r5_data_moves_on_rise_only: assert property (@(posedge clk) disable iff (rst)
    !$stable(link_sdo) |-> $rose(link_sclk));

  a_r6_strobe_high_long_enough: assert property (@(posedge clk) disable iff (rst)
    $fell(link_sync) |-> (hi_run >= HW'(SYNC_HI_CYC)));

  a_r7_idle_lines_low: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!link_sync && !link_sclk));

  a_r9_abort_raises_strobe: assert property (@(posedge clk) disable iff (rst)
    (abort_req && (seq_state == ST_LEAD || seq_state == ST_SHIFT))
      |=> (link_sync && !link_sclk && busy));

  a_r10_idle_abort_inert: assert property (@(posedge clk) disable iff (rst)
    (abort_req && req_ready && !req_valid) |=> (req_ready && !link_sync));
endmodule

bind dac_frame_writer dfw_checker #(.SYNC_HI_CYC(SYNC_HI_CYC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .abort_req(abort_req),
  .link_sync(link_sync),
  .link_sclk(link_sclk),
  .link_sdo (link_sdo),
  .busy     (busy),
  .seq_state(seq_state)
);

// File: tb/sim_dac_frame_writer.sv
module sim_dac_frame_writer;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int HALF = 4;
  localparam int SHI  = 7;
  localparam int POST = 20;

  logic        clk = 1'b0, rst = 1'b1;
  logic        req_valid = 1'b0, abort_req = 1'b0;
  logic [1:0]  req_mode = '0;
  logic [15:0] req_code = '0;
  logic        req_ready, link_sync, link_sclk, link_sdo, busy;

  int n_chk = 0, n_bad = 0, frames_done = 0;
  logic [23:0] exp_q[$];

  always #2.5 clk = ~clk;

  dac_frame_writer #(
    .HALF_CYC(HALF), .SYNC_HI_CYC(SHI), .POST_CYC(POST), .LSB_FIRST(1'b1)
  ) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_code(req_code), .abort_req(abort_req),
    .link_sync(link_sync), .link_sclk(link_sclk), .link_sdo(link_sdo), .busy(busy)
  );

  function automatic logic [23:0] frame_of(input logic [1:0] m, input logic [15:0] c);
    return {6'b000000, m, c};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // Wire monitor, sampled on the falling system clock edge.
  logic p_sync = 1'b0, p_sclk = 1'b0, p_sdo = 1'b0;
  logic [23:0] cap = '0;
  int sync_run = 0, sclk_run = 0, bits = 0, post_k = -1, since_end = -1;
  bit in_frame = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      in_frame = 1'b0; post_k = -1; since_end = -1; sync_run = 0;
    end else begin
      if (req_ready) chk(!link_sync && !link_sclk, "R7 idle keeps strobe and clock low", {link_sync, link_sclk}, 0);
      if (link_sync && link_sclk) chk(1'b0, "R4 clock high while strobe high", 1, 0);
      if (link_sdo !== p_sdo && !(link_sclk && !p_sclk))
        chk(1'b0, "R5 data changed away from a rising clock", link_sdo, p_sdo);
      if (since_end >= 0) since_end++;
      if (post_k >= 0) begin
        if (post_k == POST) begin
          chk(!busy && req_ready, "R8 busy ends POST cycles after last fall", {busy, req_ready}, 2'b01);
          post_k = -1;
        end else begin
          if (post_k == POST - 1) chk(busy, "R8 busy held until gap ends", busy, 1);
          post_k++;
        end
      end
      if (link_sync) begin
        if (!p_sync) begin sync_run = 0; in_frame = 1'b0; end
        sync_run++;
      end else if (p_sync) begin
        chk(sync_run >= SHI, "R6 strobe high time", sync_run, SHI);
        if (since_end >= 0) begin
          chk(since_end >= POST + SHI, "R8 last fall to next strobe fall", since_end, POST + SHI);
          since_end = -1;
        end
        in_frame = 1'b1; bits = 0; sclk_run = 0;
      end else if (in_frame) begin
        sclk_run++;
        if (link_sclk != p_sclk) begin
          chk(sclk_run == HALF, "R4 clock phase length", sclk_run, HALF);
          sclk_run = 0;
          if (!link_sclk) begin
            cap = {cap[22:0], link_sdo};
            bits++;
            if (bits == 24) begin
              if (exp_q.size() == 0) chk(1'b0, "R3 frame with no request", cap, 0);
              else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                chk(cap == e, "R3 frame content", cap, e);
              end
              frames_done++;
              post_k = 1;
              since_end = 0;
              chk(busy, "R8 busy at last falling edge", busy, 1);
            end else if (bits > 24) begin
              chk(1'b0, "R3 more than 24 falling edges", bits, 24);
            end
          end
        end
      end
    end
    p_sync = link_sync; p_sclk = link_sclk; p_sdo = link_sdo;
  end

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] m, input logic [15:0] c, input bit expect_out);
    wait_idle();
    req_valid = 1'b1; req_mode = m; req_code = c;
    if (expect_out) exp_q.push_back(frame_of(m, c));
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !req_ready, "R2 accepted request raises busy", {busy, req_ready}, 2'b10);
  endtask

  task automatic abort_after(input int d);
    int fd;
    send(2'($urandom), 16'($urandom), 1'b0);
    fd = frames_done;
    repeat (d) @(negedge clk);
    abort_req = 1'b1;
    @(negedge clk);
    abort_req = 1'b0;
    chk(link_sync && !link_sclk && busy, "R9 abort raises strobe next cycle",
        {link_sync, link_sclk, busy}, 3'b101);
    wait_idle();
    chk(frames_done == fd, "R9 aborted write not completed", frames_done, fd);
    chk(req_ready && !link_sync, "R9 back to idle after abort", {req_ready, link_sync}, 2'b10);
  endtask

  initial begin
    void'($urandom(32'h5EED_0017));
    repeat (3) @(negedge clk);
    chk(!link_sync && !link_sclk && !busy && req_ready, "R1 state during reset",
        {link_sync, link_sclk, busy, req_ready}, 4'b0001);
    rst = 1'b0;
    @(negedge clk);
    chk(!link_sync && !link_sclk && !busy && req_ready, "R1 state after reset",
        {link_sync, link_sclk, busy, req_ready}, 4'b0001);

    // Directed codes: zero, most negative, most positive, minus one, alternating.
    send(2'd0, 16'h0000, 1'b1);
    send(2'd3, 16'h8000, 1'b1);
    send(2'd1, 16'h7FFF, 1'b1);
    send(2'd2, 16'hFFFF, 1'b1);
    send(2'd0, 16'hA55A, 1'b1);

    // R2: a request held while busy must not start an extra frame.
    send(2'd1, 16'h1234, 1'b1);
    req_valid = 1'b1; req_mode = 2'd3; req_code = 16'hDEAD;
    repeat (10) begin
      @(negedge clk);
      chk(!req_ready && busy, "R2 request held while busy not taken", {req_ready, busy}, 2'b01);
    end
    req_valid = 1'b0;

    // R10: abort while idle.
    wait_idle();
    abort_req = 1'b1;
    @(negedge clk);
    abort_req = 1'b0;
    chk(req_ready && !link_sync && !busy, "R10 idle abort has no effect",
        {req_ready, link_sync, busy}, 3'b100);

    // R9: aborts in the lead, the first byte, and the third byte.
    abort_after(2);
    send(2'd2, 16'h0F0F, 1'b1);
    abort_after(30);
    abort_after(150);
    send(2'd1, 16'hC3C3, 1'b1);

    // Random stream with random idle spacing.
    for (int i = 0; i < 30; i++) begin
      repeat ($urandom_range(0, 5)) @(negedge clk);
      send(2'($urandom), 16'($urandom), 1'b1);
    end

    wait_idle();
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R3 every request delivered", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R2 watchdog: run did not finish actual=0x0 expected=0x1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule